// File: doc/BRIEF.md
# Indexed Codec Control Register Bank

This block is the control-register front end of an audio codec. A host reaches it over a simple word bus with separate write and read strobes. A small window of sixteen 32-bit direct registers is decoded from the byte address. Behind that window sits a bank of thirty-two 8-bit registers that the host cannot address directly.

To reach an entry of the hidden bank, the host first writes its number into the index register (direct word 0). It then reads or writes the data-port word (direct word 1), which always refers to the entry the index currently selects. A few entries behave in special ways:

- One entry can be written but never read back.
- Two entries cannot be changed by the host.
- One entry carries a fixed version code next to a single writable bit.
- Direct word 4 is a control word whose lowest bit, when written as 1, restores every register to its power-up value within that same write.

Read data is registered and arrives one clock after the read strobe.

Top module: `codec_idx_regs`

## Requirements
- R1: After the hardware reset, every direct register and every indirect entry reads 0, except indirect entry 12, which reads 0x8A, and indirect entry 25, which reads 0xA0. The read data output is 0.
- R2: The direct word is chosen by byte-address bits [5:2]. Address bits above bit 5 and the two lowest bits have no effect, so byte addresses 0x7C and 0xFC both reach word 15.
- R3: The index is bits [4:0] of direct word 0. Writing word 1 stores write-data bits [7:0] into the selected entry. Reading word 1 returns the selected entry zero-extended to 32 bits.
- R4: Reading word 1 while the index is 3 returns 0, even after a value was written there.
- R5: Writes through word 1 to entries 11 and 25 leave those entries unchanged.
- R6: A write through word 1 to entry 12 stores (write-data & 0x40) | 0x8A.
- R7: Writes to direct word 2 are ignored, and word 2 reads 0.
- R8: A write to direct word 4 stores write-data & 0x7F. When bit 0 is clear, no other register changes.
- R9: A write to word 4 with bit 0 set first returns every register to its R1 value and then stores write-data & 0x7F into word 4, all in one cycle.
- R10: rdData takes a new value only on the clock edge that samples rdEn high, and it holds that value otherwise. A read and a write in the same cycle return the contents from before the write.
- R11: Direct words 0, 3 and 5 to 15 store and return all 32 bits of the write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| busAddr | input | 8 | Byte address |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Registered read data |

## Verification
The hardest case to reach from the ports is the soft reset that writes its own register. It restores everything and stores a new control value in the same edge, and the effect is only visible through later reads of registers that were changed beforehand. The stimulus first loads the index, a hidden entry and a direct word with non-reset values. It then issues the control write with bit 0 set and reads each of them back, re-aiming the index to inspect the hidden entries. A read and a write issued on the same edge are also driven, to pin down the read-before-write ordering.

// File: rtl/codec_idx_pkg.sv
package codec_idx_pkg;
  localparam int DW     = 32;
  localparam int IW     = 8;
  localparam int DIR_N  = 16;
  localparam int IND_N  = 32;
  localparam int DIR_AW = $clog2(DIR_N);
  localparam int IND_AW = $clog2(IND_N);

  localparam logic [DIR_AW-1:0] IDX_WORD    = 0;
  localparam logic [DIR_AW-1:0] PORT_WORD   = 1;
  localparam logic [DIR_AW-1:0] LOCKED_WORD = 2;
  localparam logic [DIR_AW-1:0] CTRL_WORD   = 4;

  localparam logic [IND_AW-1:0] WO_ENTRY   = 3;
  localparam logic [IND_AW-1:0] RO_ENTRY_A = 11;
  localparam logic [IND_AW-1:0] VER_ENTRY  = 12;
  localparam logic [IND_AW-1:0] RO_ENTRY_B = 25;

  localparam logic [IW-1:0] VER_CODE  = 8'h8A;
  localparam logic [IW-1:0] ID_CODE   = 8'hA0;
  localparam logic [IW-1:0] VER_KEEP  = 8'h40;
  localparam logic [DW-1:0] CTRL_KEEP = 32'h0000_007F;
  localparam int            SOFT_BIT  = 0;

  typedef struct packed {
    logic              dirWe;
    logic [DIR_AW-1:0] dirIdx;
    logic [DW-1:0]     dirVal;
    logic              indWe;
    logic [IND_AW-1:0] indIdx;
    logic [IW-1:0]     indVal;
    logic              softRst;
    logic              rdStb;
    logic              rdPort;
    logic              rdZero;
    logic [DIR_AW-1:0] rdIdx;
  } regCmd_t;

  function automatic logic [IW-1:0] indResetVal(int idx);
    if (idx == int'(VER_ENTRY))       return VER_CODE;
    else if (idx == int'(RO_ENTRY_B)) return ID_CODE;
    else                              return '0;
  endfunction
endpackage

// File: rtl/codec_idx_ctrl.sv
module codec_idx_ctrl
  import codec_idx_pkg::*;
(
  input  logic [DIR_AW-1:0] wordIdx,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DW-1:0]     wrData,
  input  logic [IND_AW-1:0] curIdx,
  output regCmd_t           cmd
);
  logic isPort;
  logic isReadOnly;

  assign isPort     = (wordIdx == PORT_WORD);
  assign isReadOnly = (curIdx == RO_ENTRY_A) || (curIdx == RO_ENTRY_B);

  always_comb begin
    cmd        = '0;
    cmd.dirIdx = wordIdx;
    cmd.indIdx = curIdx;
    cmd.rdStb  = rdEn;
    cmd.rdIdx  = wordIdx;
    cmd.rdPort = isPort;
    cmd.rdZero = isPort && (curIdx == WO_ENTRY);
    if (wrEn) begin
      if (isPort) begin
        if (!isReadOnly) begin
          cmd.indWe  = 1'b1;
          cmd.indVal = (curIdx == VER_ENTRY) ? ((wrData[IW-1:0] & VER_KEEP) | VER_CODE)
                                             : wrData[IW-1:0];
        end
      end else if (wordIdx == CTRL_WORD) begin
        cmd.dirWe   = 1'b1;
        cmd.dirVal  = wrData & CTRL_KEEP;
        cmd.softRst = wrData[SOFT_BIT];
      end else if (wordIdx != LOCKED_WORD) begin
        cmd.dirWe  = 1'b1;
        cmd.dirVal = wrData;
      end
    end
  end
endmodule

// File: rtl/codec_idx_data.sv
module codec_idx_data
  import codec_idx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  regCmd_t           cmd,
  output logic [IND_AW-1:0] curIdx,
  output logic [DW-1:0]     rdData
);
  logic [DW-1:0] dirRegs [DIR_N];
  logic [IW-1:0] indRegs [IND_N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DIR_N; i++) dirRegs[i] <= '0;
      for (int j = 0; j < IND_N; j++) indRegs[j] <= indResetVal(j);
    end else begin
      if (cmd.softRst) begin
        for (int i = 0; i < DIR_N; i++) dirRegs[i] <= '0;
        for (int j = 0; j < IND_N; j++) indRegs[j] <= indResetVal(j);
      end
      if (cmd.dirWe) dirRegs[cmd.dirIdx] <= cmd.dirVal;
      if (cmd.indWe) indRegs[cmd.indIdx] <= cmd.indVal;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdData <= '0;
    else if (cmd.rdStb) begin
      if (cmd.rdPort)
        rdData <= cmd.rdZero ? '0 : {{(DW-IW){1'b0}}, indRegs[cmd.indIdx]};
      else
        rdData <= dirRegs[cmd.rdIdx];
    end
  end

  assign curIdx = dirRegs[IDX_WORD][IND_AW-1:0];

  assert_ver_field_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (indRegs[VER_ENTRY] & ~VER_KEEP) == VER_CODE);
  assert_ro_id_R5: assert property (@(posedge clk) disable iff (!rst_n)
    indRegs[RO_ENTRY_B] == ID_CODE);
  assert_ro_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd.softRst |=> $stable(indRegs[RO_ENTRY_A]));
  assert_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dirRegs[LOCKED_WORD] == '0);
  assert_ctrl_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dirRegs[CTRL_WORD] & ~CTRL_KEEP) == '0);
  assert_wo_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.rdStb && cmd.rdZero |=> rdData == '0);
  assert_soft_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.softRst |=> dirRegs[IDX_WORD] == '0);
  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd.rdStb |=> $stable(rdData));
endmodule

// File: rtl/codec_idx_regs.sv
module codec_idx_regs
  import codec_idx_pkg::*;
#(
  parameter int BUS_AW = 8,
  parameter int WIN_AW = DIR_AW + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_AW-1:0] busAddr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DW-1:0]     wrData,
  output logic [DW-1:0]     rdData
);
  regCmd_t           cmd;
  logic [IND_AW-1:0] curIdx;
  logic [DIR_AW-1:0] wordIdx;
  logic              unusedBits;

  assign wordIdx    = busAddr[WIN_AW-1:2];
  assign unusedBits = ^{busAddr[BUS_AW-1:WIN_AW], busAddr[1:0]};

  codec_idx_ctrl u_ctrl (
    .wordIdx (wordIdx),
    .wrEn    (wrEn),
    .rdEn    (rdEn),
    .wrData  (wrData),
    .curIdx  (curIdx),
    .cmd     (cmd)
  );

  codec_idx_data u_data (
    .clk    (clk),
    .rst_n  (rst_n),
    .cmd    (cmd),
    .curIdx (curIdx),
    .rdData (rdData)
  );
endmodule

// File: tb/codec_idx_regs_test.sv
module codec_idx_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  int total = 0;
  int bad = 0;
  int cycles = 0;

  codec_idx_regs uut (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .wrEn(wrEn),
    .rdEn(rdEn), .wrData(wrData), .rdData(rdData)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles >= 100000) begin
      bad++;
      $display("FAIL watchdog: got %0d cycles exp fewer", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // entry: {isRead, byteAddr, value (write data or expected read), requirement}
  localparam int NV = 33;
  localparam logic [44:0] VEC [NV] = '{
    {1'b0, 8'h00, 32'h0000_0005, 4'd3},  // R3 index 5
    {1'b0, 8'h04, 32'h1234_56C3, 4'd3},  // R3 only low byte kept
    {1'b1, 8'h04, 32'h0000_00C3, 4'd3},
    {1'b1, 8'h00, 32'h0000_0005, 4'd11},
    {1'b0, 8'h00, 32'hFFFF_FFE3, 4'd11}, // R11 full word, index 3
    {1'b1, 8'h00, 32'hFFFF_FFE3, 4'd11},
    {1'b0, 8'h04, 32'h0000_0077, 4'd4},  // R4 write-only entry
    {1'b1, 8'h04, 32'h0000_0000, 4'd4},
    {1'b0, 8'h00, 32'h0000_000B, 4'd5},  // R5 entry 11
    {1'b0, 8'h04, 32'h0000_0055, 4'd5},
    {1'b1, 8'h04, 32'h0000_0000, 4'd5},
    {1'b0, 8'h00, 32'h0000_0019, 4'd5},  // R5 entry 25
    {1'b0, 8'h04, 32'h0000_0012, 4'd5},
    {1'b1, 8'h04, 32'h0000_00A0, 4'd5},
    {1'b0, 8'h00, 32'h0000_000C, 4'd6},  // R6 version entry
    {1'b0, 8'h04, 32'h0000_00FF, 4'd6},
    {1'b1, 8'h04, 32'h0000_00CA, 4'd6},
    {1'b0, 8'h04, 32'h0000_0000, 4'd6},
    {1'b1, 8'h04, 32'h0000_008A, 4'd6},
    {1'b0, 8'h08, 32'h0000_DEAD, 4'd7},  // R7 locked word
    {1'b1, 8'h08, 32'h0000_0000, 4'd7},
    {1'b0, 8'h10, 32'hFFFF_FF7E, 4'd8},  // R8 mask, bit 0 clear
    {1'b1, 8'h10, 32'h0000_007E, 4'd8},
    {1'b1, 8'h00, 32'h0000_000C, 4'd8},  // R8 index untouched
    {1'b0, 8'h7C, 32'h0000_CAFE, 4'd2},  // R2 aliasing
    {1'b1, 8'h3C, 32'h0000_CAFE, 4'd2},
    {1'b1, 8'hFC, 32'h0000_CAFE, 4'd2},
    {1'b0, 8'h2C, 32'hA5A5_5A5A, 4'd11},
    {1'b1, 8'hEC, 32'hA5A5_5A5A, 4'd2},
    {1'b0, 8'h00, 32'h0000_0027, 4'd3},  // R3 index from low 5 bits
    {1'b0, 8'h04, 32'h0000_003C, 4'd3},
    {1'b0, 8'h00, 32'h0000_0007, 4'd3},
    {1'b1, 8'h04, 32'h0000_003C, 4'd3}
  };

  task automatic check(input logic [31:0] got, input logic [31:0] exp, input string req);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h exp %h", req, got, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  task automatic readIdx(input logic [4:0] idx, output logic [31:0] d);
    busWrite(8'h00, {27'd0, idx});
    busRead(8'h04, d);
  endtask

  initial begin
    logic [31:0] v;
    logic [31:0] held;
    repeat (3) @(negedge clk);
    check(rdData, 32'h0, "R1 rdData at reset");
    rst_n = 1'b1;
    busRead(8'h3C, v); check(v, 32'h0, "R1 word15 reset");
    readIdx(5'd12, v); check(v, 32'h8A, "R1 entry12 reset");

    for (int k = 0; k < NV; k++) begin
      if (VEC[k][44]) begin
        busRead(VEC[k][43:36], v);
        check(v, VEC[k][35:4], $sformatf("R%0d vector %0d", VEC[k][3:0], k));
      end else begin
        busWrite(VEC[k][43:36], VEC[k][35:4]);
      end
    end

    // R10: hold without strobe, and read-before-write ordering
    busRead(8'h2C, held);
    repeat (3) @(negedge clk);
    check(rdData, held, "R10 hold");
    busWrite(8'h18, 32'h11);
    @(negedge clk);
    busAddr = 8'h18; wrData = 32'h22; wrEn = 1'b1; rdEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
    check(rdData, 32'h11, "R10 same-cycle old value");
    busRead(8'h18, v); check(v, 32'h22, "R10 new value");

    // R9: soft reset through control word
    busWrite(8'h00, 32'h7);
    busWrite(8'h04, 32'h66);
    busWrite(8'h14, 32'h99);
    busWrite(8'h10, 32'hFFFF_FF81);
    busRead(8'h10, v); check(v, 32'h01, "R9 control stored after reset");
    busRead(8'h00, v); check(v, 32'h0, "R9 index cleared");
    busRead(8'h14, v); check(v, 32'h0, "R9 word5 cleared");
    busRead(8'h04, v); check(v, 32'h0, "R9 entry0");
    readIdx(5'd7, v);  check(v, 32'h0, "R9 entry7 cleared");
    readIdx(5'd12, v); check(v, 32'h8A, "R9 entry12 restored");
    readIdx(5'd25, v); check(v, 32'hA0, "R9 entry25 restored");

    // R1: hardware reset in mid-run
    busWrite(8'h18, 32'h5A);
    readIdx(5'd12, v);
    busWrite(8'h04, 32'h40);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(rdData, 32'h0, "R1 rdData after hw reset");
    rst_n = 1'b1;
    busRead(8'h18, v); check(v, 32'h0, "R1 word6 after hw reset");
    busRead(8'h00, v); check(v, 32'h0, "R1 index after hw reset");
    readIdx(5'd12, v); check(v, 32'h8A, "R1 entry12 after hw reset");
    readIdx(5'd25, v); check(v, 32'hA0, "R1 entry25 after hw reset");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule